// File: doc/BRIEF.md
# Execution-Tagged Operand Filter with Wave Replay

This block sits in front of the operand matching logic of a dataflow machine that runs several waves speculatively. Each wave slot has an execution number. Every incoming operand carries a wave slot index and the execution number it was produced under. Operands whose tag equals the slot's current execution number are forwarded. Operands with any other tag come from a squashed execution, and the block drops them.

The block also keeps a small per-wave context store. It records the input operands that were handed to each wave, using a capture port. When a wave commits, its saved operands are freed.

An abort names the oldest squashed wave. On that event:
- Every slot at that index or above gets its execution number advanced by one.
- The block then walks those slots in ascending order and re-emits every saved operand, tagged with the slot's new execution number.
- The operand input is stalled during this replay, so the replayed operands reach the output ahead of any new traffic.

Top module: `ofp_filter_top`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, ctx_overflow is 0, and every slot's execution number is 0, so an operand tagged 0 passes for any slot.
- R2: Suppose an operand is accepted (in_valid and in_ready both high) and its tag equals its slot's execution number. On the next cycle it appears on the output for exactly one cycle, with the same wave, tag and data, and with out_replay at 0.
- R3: An accepted operand whose tag differs from its slot's execution number produces no output.
- R4: An abort naming slot X adds one to the execution number of every slot whose index is X or greater. Slots below X keep their number.
- R5: After an abort naming X, the saved operands of slots X up to the last slot are emitted. The order is ascending slot index first, then capture order within a slot. Each carries out_replay at 1 and its slot's new execution number.
- R6: in_ready is 0 in the cycle abort_valid is high and for the whole replay. It returns to 1 once the replay ends.
- R7: A commit for a slot empties that slot's saved operands, so a later abort replays nothing for it. If a commit and a capture for the same slot arrive in the same cycle, the commit wins and the capture is dropped.
- R8: Each slot holds at most CTX_SLOTS saved operands. A capture into a full slot is discarded and sets ctx_overflow, which then stays at 1 until reset.
- R9: Execution numbers count modulo 2^EXEN_W. After 2^EXEN_W aborts covering a slot, tag 0 passes again for that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming operand valid |
| in_ready | output | 1 | Operand input can accept |
| in_wave | input | WAVE_IDX_W | Wave slot of incoming operand |
| in_exen | input | EXEN_W | Execution-number tag of incoming operand |
| in_data | input | DATA_W | Operand value |
| out_valid | output | 1 | Forwarded or replayed operand valid |
| out_wave | output | WAVE_IDX_W | Wave slot of output operand |
| out_exen | output | EXEN_W | Execution number of output operand |
| out_data | output | DATA_W | Output operand value |
| out_replay | output | 1 | Output operand comes from the context store |
| abort_valid | input | 1 | Abort event |
| abort_wave | input | WAVE_IDX_W | Oldest squashed wave slot |
| cap_valid | input | 1 | Save an operand into the context store |
| cap_wave | input | WAVE_IDX_W | Slot receiving the saved operand |
| cap_data | input | DATA_W | Saved operand value |
| commit_valid | input | 1 | Wave commit event |
| commit_wave | input | WAVE_IDX_W | Committing wave slot |
| ctx_overflow | output | 1 | Sticky flag: a capture hit a full slot |

## Verification
Operands with matching tags are sent to several different slots with different data. This separates correct forwarding from cross-slot mixing. Stale tags are sent both below and above the current execution number, to show that the check is an equality test and not an ordering test.

Aborts are issued at the lowest slot, at a middle slot and at the top slot, over slots holding differing numbers of saved operands. The replay order and tags then show whether slot range, capture order, commit clearing and overflow truncation are each respected. Repeated aborts on one slot push its counter past the wrap point, and a tag-0 operand is sent afterwards. A separate capture goes into an already committed-and-empty slot in the same cycle as that slot's commit, and the following abort must replay nothing for it.

// File: rtl/ofp_pkg.sv
package ofp_pkg;

    // Replay sequencer state
    typedef enum logic {
        RP_IDLE = 1'b0,
        RP_RUN  = 1'b1
    } rp_state_e;

    // Index width that never collapses to zero bits
    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Counter width able to hold the value n itself
    function automatic int unsigned cnt_w(input int unsigned n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/ofp_exen_table.sv
module ofp_exen_table #(
    parameter int unsigned NUM_WAVES = 4,
    parameter int unsigned EXEN_W    = 3,
    localparam int unsigned WW       = ofp_pkg::idx_w(NUM_WAVES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              abort_valid,
    input  logic [WW-1:0]     abort_wave,
    input  logic [WW-1:0]     rd_a_wave,
    output logic [EXEN_W-1:0] rd_a_exen,
    input  logic [WW-1:0]     rd_b_wave,
    output logic [EXEN_W-1:0] rd_b_exen
);

    logic [EXEN_W-1:0] tab [NUM_WAVES];

    // Every slot at or above the squashed one advances; wraps naturally
    generate
        for (genvar w = 0; w < NUM_WAVES; w++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    tab[w] <= '0;
                end else if (abort_valid && (WW'(w) >= abort_wave)) begin
                    tab[w] <= tab[w] + EXEN_W'(1);
                end
            end
        end
    endgenerate

    assign rd_a_exen = tab[rd_a_wave];
    assign rd_b_exen = tab[rd_b_wave];

endmodule

// File: rtl/ofp_ctx_store.sv
module ofp_ctx_store #(
    parameter int unsigned NUM_WAVES = 4,
    parameter int unsigned CTX_SLOTS = 4,
    parameter int unsigned DATA_W    = 16,
    localparam int unsigned WW       = ofp_pkg::idx_w(NUM_WAVES),
    localparam int unsigned SW       = ofp_pkg::idx_w(CTX_SLOTS),
    localparam int unsigned CW       = ofp_pkg::cnt_w(CTX_SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_valid,
    input  logic [WW-1:0]     cap_wave,
    input  logic [DATA_W-1:0] cap_data,
    input  logic              commit_valid,
    input  logic [WW-1:0]     commit_wave,
    input  logic [WW-1:0]     rd_wave,
    input  logic [SW-1:0]     rd_slot,
    output logic [DATA_W-1:0] rd_data,
    output logic [CW-1:0]     rd_cnt,
    output logic              overflow
);

    logic [DATA_W-1:0] mem [NUM_WAVES][CTX_SLOTS];
    logic [CW-1:0]     cnt [NUM_WAVES];

    logic          cap_blocked;
    logic          cap_full;
    logic          cap_write;
    logic [CW-1:0] cap_cnt;

    assign cap_blocked = commit_valid && (commit_wave == cap_wave);
    assign cap_cnt     = cnt[cap_wave];
    assign cap_full    = (cap_cnt == CW'(CTX_SLOTS));
    assign cap_write   = cap_valid && !cap_blocked && !cap_full;

    generate
        for (genvar w = 0; w < NUM_WAVES; w++) begin : g_cnt
            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt[w] <= '0;
                end else if (commit_valid && (commit_wave == WW'(w))) begin
                    cnt[w] <= '0;
                end else if (cap_write && (cap_wave == WW'(w))) begin
                    cnt[w] <= cnt[w] + CW'(1);
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (cap_write) begin
            mem[cap_wave][cap_cnt[SW-1:0]] <= cap_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            overflow <= 1'b0;
        end else if (cap_valid && !cap_blocked && cap_full) begin
            overflow <= 1'b1;
        end
    end

    assign rd_data = mem[rd_wave][rd_slot];
    assign rd_cnt  = cnt[rd_wave];

endmodule

// File: rtl/ofp_replay_seq.sv
module ofp_replay_seq #(
    parameter int unsigned NUM_WAVES = 4,
    parameter int unsigned CTX_SLOTS = 4,
    localparam int unsigned WW       = ofp_pkg::idx_w(NUM_WAVES),
    localparam int unsigned SW       = ofp_pkg::idx_w(CTX_SLOTS),
    localparam int unsigned CW       = ofp_pkg::cnt_w(CTX_SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          abort_valid,
    input  logic [WW-1:0] abort_wave,
    input  logic [CW-1:0] cur_cnt,
    output logic          busy,
    output logic          emit,
    output logic [WW-1:0] cur_wave,
    output logic [SW-1:0] cur_slot
);

    import ofp_pkg::*;

    rp_state_e     state;
    logic [WW-1:0] wave_q;
    logic [CW-1:0] slot_q;
    logic          has_more;

    assign has_more = (slot_q < cur_cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= RP_IDLE;
            wave_q <= '0;
            slot_q <= '0;
        end else if (abort_valid) begin
            // A nested abort restarts at the older of the two positions
            state  <= RP_RUN;
            wave_q <= (state == RP_RUN && wave_q < abort_wave) ? wave_q : abort_wave;
            slot_q <= '0;
        end else if (state == RP_RUN) begin
            if (has_more) begin
                slot_q <= slot_q + CW'(1);
            end else if (wave_q == WW'(NUM_WAVES - 1)) begin
                state <= RP_IDLE;
            end else begin
                wave_q <= wave_q + WW'(1);
                slot_q <= '0;
            end
        end
    end

    assign busy     = (state == RP_RUN);
    assign emit     = busy && has_more && !abort_valid;
    assign cur_wave = wave_q;
    assign cur_slot = slot_q[SW-1:0];

endmodule

// File: rtl/ofp_filter_top.sv
module ofp_filter_top #(
    parameter int unsigned NUM_WAVES  = 4,
    parameter int unsigned EXEN_W     = 3,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned CTX_SLOTS  = 4,
    localparam int unsigned WAVE_IDX_W = ofp_pkg::idx_w(NUM_WAVES),
    localparam int unsigned SW         = ofp_pkg::idx_w(CTX_SLOTS),
    localparam int unsigned CW         = ofp_pkg::cnt_w(CTX_SLOTS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [WAVE_IDX_W-1:0] in_wave,
    input  logic [EXEN_W-1:0]     in_exen,
    input  logic [DATA_W-1:0]     in_data,
    output logic                  out_valid,
    output logic [WAVE_IDX_W-1:0] out_wave,
    output logic [EXEN_W-1:0]     out_exen,
    output logic [DATA_W-1:0]     out_data,
    output logic                  out_replay,
    input  logic                  abort_valid,
    input  logic [WAVE_IDX_W-1:0] abort_wave,
    input  logic                  cap_valid,
    input  logic [WAVE_IDX_W-1:0] cap_wave,
    input  logic [DATA_W-1:0]     cap_data,
    input  logic                  commit_valid,
    input  logic [WAVE_IDX_W-1:0] commit_wave,
    output logic                  ctx_overflow
);

    typedef struct packed {
        logic [WAVE_IDX_W-1:0] wave;
        logic [EXEN_W-1:0]     exen;
        logic [DATA_W-1:0]     data;
        logic                  replay;
    } operand_t;

    logic [EXEN_W-1:0]     cur_exen_in;
    logic [EXEN_W-1:0]     cur_exen_rp;
    logic                  rp_busy;
    logic                  rp_emit;
    logic [WAVE_IDX_W-1:0] rp_wave;
    logic [SW-1:0]         rp_slot;
    logic [DATA_W-1:0]     rp_data;
    logic [CW-1:0]         rp_cnt;
    logic                  accept;
    logic                  tag_ok;
    operand_t              nxt_op;
    operand_t              out_op;
    logic                  nxt_valid;

    ofp_exen_table #(
        .NUM_WAVES (NUM_WAVES),
        .EXEN_W    (EXEN_W)
    ) u_table (
        .clk         (clk),
        .rst         (rst),
        .abort_valid (abort_valid),
        .abort_wave  (abort_wave),
        .rd_a_wave   (in_wave),
        .rd_a_exen   (cur_exen_in),
        .rd_b_wave   (rp_wave),
        .rd_b_exen   (cur_exen_rp)
    );

    ofp_ctx_store #(
        .NUM_WAVES (NUM_WAVES),
        .CTX_SLOTS (CTX_SLOTS),
        .DATA_W    (DATA_W)
    ) u_ctx (
        .clk          (clk),
        .rst          (rst),
        .cap_valid    (cap_valid),
        .cap_wave     (cap_wave),
        .cap_data     (cap_data),
        .commit_valid (commit_valid),
        .commit_wave  (commit_wave),
        .rd_wave      (rp_wave),
        .rd_slot      (rp_slot),
        .rd_data      (rp_data),
        .rd_cnt       (rp_cnt),
        .overflow     (ctx_overflow)
    );

    ofp_replay_seq #(
        .NUM_WAVES (NUM_WAVES),
        .CTX_SLOTS (CTX_SLOTS)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .abort_valid (abort_valid),
        .abort_wave  (abort_wave),
        .cur_cnt     (rp_cnt),
        .busy        (rp_busy),
        .emit        (rp_emit),
        .cur_wave    (rp_wave),
        .cur_slot    (rp_slot)
    );

    // New operands wait while an abort lands or a replay runs
    assign in_ready = !rp_busy && !abort_valid;
    assign accept   = in_valid && in_ready;
    assign tag_ok   = (in_exen == cur_exen_in);

    always_comb begin
        nxt_valid = 1'b0;
        nxt_op    = '0;
        if (rp_emit) begin
            nxt_valid     = 1'b1;
            nxt_op.wave   = rp_wave;
            nxt_op.exen   = cur_exen_rp;
            nxt_op.data   = rp_data;
            nxt_op.replay = 1'b1;
        end else if (accept && tag_ok) begin
            nxt_valid     = 1'b1;
            nxt_op.wave   = in_wave;
            nxt_op.exen   = in_exen;
            nxt_op.data   = in_data;
            nxt_op.replay = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_op    <= '0;
        end else begin
            out_valid <= nxt_valid;
            if (nxt_valid) begin
                out_op <= nxt_op;
            end
        end
    end

    assign out_wave   = out_op.wave;
    assign out_exen   = out_op.exen;
    assign out_data   = out_op.data;
    assign out_replay = out_op.replay;

endmodule

// File: rtl/ofp_filter_checker.sv
module ofp_filter_checker #(
    parameter int unsigned EXEN_W = 3,
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [EXEN_W-1:0] in_exen,
    input logic [DATA_W-1:0] in_data,
    input logic [EXEN_W-1:0] slot_exen,
    input logic              busy,
    input logic              abort_valid,
    input logic              cap_valid,
    input logic              out_valid,
    input logic              out_replay,
    input logic [DATA_W-1:0] out_data,
    input logic              ctx_overflow
);

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !ctx_overflow)); // R1

    AST_FWD_MATCH: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_exen == slot_exen) |=>
            (out_valid && !out_replay && out_data == $past(in_data))); // R2

    AST_DROP_STALE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_exen != slot_exen && !busy) |=> !out_valid); // R3

    AST_STALL_REPLAY: assert property (@(posedge clk) disable iff (rst)
        (busy || abort_valid) |-> !in_ready); // R6

    AST_REPLAY_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_replay) |-> $past(busy)); // R5

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ctx_overflow |=> ctx_overflow); // R8

    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(ctx_overflow) |-> $past(cap_valid)); // R8

endmodule

bind ofp_filter_top ofp_filter_checker #(
    .EXEN_W (EXEN_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_exen      (in_exen),
    .in_data      (in_data),
    .slot_exen    (cur_exen_in),
    .busy         (rp_busy),
    .abort_valid  (abort_valid),
    .cap_valid    (cap_valid),
    .out_valid    (out_valid),
    .out_replay   (out_replay),
    .out_data     (out_data),
    .ctx_overflow (ctx_overflow)
);

// File: tb/ofp_filter_top_test.sv
`timescale 1ns/1ps
module ofp_filter_top_test;

    localparam int WW = 2;
    localparam int EW = 3;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [WW-1:0] in_wave = '0;
    logic [EW-1:0] in_exen = '0;
    logic [DW-1:0] in_data = '0;
    logic          out_valid;
    logic [WW-1:0] out_wave;
    logic [EW-1:0] out_exen;
    logic [DW-1:0] out_data;
    logic          out_replay;
    logic          abort_valid = 1'b0;
    logic [WW-1:0] abort_wave = '0;
    logic          cap_valid = 1'b0;
    logic [WW-1:0] cap_wave = '0;
    logic [DW-1:0] cap_data = '0;
    logic          commit_valid = 1'b0;
    logic [WW-1:0] commit_wave = '0;
    logic          ctx_overflow;

    int n_checks = 0;
    int n_fail   = 0;

    logic [WW-1:0] lg_wave [64];
    logic [EW-1:0] lg_exen [64];
    logic [DW-1:0] lg_data [64];
    logic          lg_rep  [64];
    int            lg_n = 0;

    always #5 clk = ~clk;

    ofp_filter_top #(
        .NUM_WAVES (4),
        .EXEN_W    (EW),
        .DATA_W    (DW),
        .CTX_SLOTS (4)
    ) uut (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_wave      (in_wave),
        .in_exen      (in_exen),
        .in_data      (in_data),
        .out_valid    (out_valid),
        .out_wave     (out_wave),
        .out_exen     (out_exen),
        .out_data     (out_data),
        .out_replay   (out_replay),
        .abort_valid  (abort_valid),
        .abort_wave   (abort_wave),
        .cap_valid    (cap_valid),
        .cap_wave     (cap_wave),
        .cap_data     (cap_data),
        .commit_valid (commit_valid),
        .commit_wave  (commit_wave),
        .ctx_overflow (ctx_overflow)
    );

    // Output log, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst && out_valid && lg_n < 64) begin
            lg_wave[lg_n] = out_wave;
            lg_exen[lg_n] = out_exen;
            lg_data[lg_n] = out_data;
            lg_rep[lg_n]  = out_replay;
            lg_n = lg_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_entry(input int i, input logic [WW-1:0] w, input logic [EW-1:0] e,
                             input logic [DW-1:0] d, input logic r, input string req);
        logic [31:0] act;
        logic [31:0] exp;
        act = {lg_rep[i], 1'b0, lg_wave[i], 1'b0, lg_exen[i], lg_data[i]};
        exp = {r, 1'b0, w, 1'b0, e, d};
        check(i < lg_n && act == exp, req, $sformatf("entry %0d {rep,wave,exen,data}", i), act, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [WW-1:0] w, input logic [EW-1:0] e, input logic [DW-1:0] d);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_wave = w; in_exen = e; in_data = d;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic capture(input logic [WW-1:0] w, input logic [DW-1:0] d);
        @(negedge clk);
        cap_valid = 1'b1; cap_wave = w; cap_data = d;
        @(negedge clk);
        cap_valid = 1'b0;
    endtask

    task automatic commit(input logic [WW-1:0] w);
        @(negedge clk);
        commit_valid = 1'b1; commit_wave = w;
        @(negedge clk);
        commit_valid = 1'b0;
    endtask

    // Abort, then wait for the replay to finish; returns stalled cycles
    task automatic abort(input logic [WW-1:0] w, output int stalled);
        @(negedge clk);
        abort_valid = 1'b1; abort_wave = w;
        #1;
        check(in_ready == 1'b0, "R6", "in_ready in abort cycle", {31'd0, in_ready}, 32'd0);
        @(negedge clk);
        abort_valid = 1'b0;
        stalled = 0;
        while (!in_ready && stalled < 100) begin
            stalled++;
            @(negedge clk);
        end
        idle(2);
    endtask

    task automatic t_reset();
        check(in_ready == 1'b1, "R1", "in_ready after reset", {31'd0, in_ready}, 32'd1);
        check(out_valid == 1'b0, "R1", "out_valid after reset", {31'd0, out_valid}, 32'd0);
        check(ctx_overflow == 1'b0, "R1", "overflow after reset", {31'd0, ctx_overflow}, 32'd0);
    endtask

    task automatic t_forward();
        lg_n = 0;
        send(2'd0, 3'd0, 16'h0011);
        send(2'd2, 3'd0, 16'h0022);
        send(2'd3, 3'd0, 16'hA5A5);
        idle(3);
        check(lg_n == 3, "R2", "forwarded count", lg_n, 3);
        chk_entry(0, 2'd0, 3'd0, 16'h0011, 1'b0, "R2");
        chk_entry(1, 2'd2, 3'd0, 16'h0022, 1'b0, "R2");
        chk_entry(2, 2'd3, 3'd0, 16'hA5A5, 1'b0, "R1");
    endtask

    task automatic t_stale();
        lg_n = 0;
        send(2'd1, 3'd1, 16'h0033);
        send(2'd2, 3'd5, 16'h0044);
        idle(3);
        check(lg_n == 0, "R3", "stale tags dropped", lg_n, 0);
    endtask

    task automatic t_abort_replay();
        int st;
        capture(2'd1, 16'h0101);
        capture(2'd1, 16'h0102);
        capture(2'd2, 16'h0201);
        capture(2'd0, 16'h0001);
        capture(2'd3, 16'h0301);
        idle(2);
        lg_n = 0;
        abort(2'd1, st);
        check(st >= 4, "R6", "stall cycles during replay", st, 4);
        check(in_ready == 1'b1, "R6", "in_ready after replay", {31'd0, in_ready}, 32'd1);
        check(lg_n == 4, "R5", "replayed count", lg_n, 4);
        chk_entry(0, 2'd1, 3'd1, 16'h0101, 1'b1, "R5");
        chk_entry(1, 2'd1, 3'd1, 16'h0102, 1'b1, "R5");
        chk_entry(2, 2'd2, 3'd1, 16'h0201, 1'b1, "R5");
        chk_entry(3, 2'd3, 3'd1, 16'h0301, 1'b1, "R5");
        lg_n = 0;
        send(2'd0, 3'd0, 16'h0A00);
        send(2'd1, 3'd0, 16'h0A10);
        send(2'd1, 3'd1, 16'h0A11);
        send(2'd3, 3'd1, 16'h0A31);
        idle(3);
        check(lg_n == 3, "R4", "post-abort forwarded count", lg_n, 3);
        chk_entry(0, 2'd0, 3'd0, 16'h0A00, 1'b0, "R4");
        chk_entry(1, 2'd1, 3'd1, 16'h0A11, 1'b0, "R4");
        chk_entry(2, 2'd3, 3'd1, 16'h0A31, 1'b0, "R4");
    endtask

    task automatic t_commit();
        int st;
        commit(2'd1);
        lg_n = 0;
        abort(2'd1, st);
        check(lg_n == 2, "R7", "replay count after commit", lg_n, 2);
        chk_entry(0, 2'd2, 3'd2, 16'h0201, 1'b1, "R7");
        chk_entry(1, 2'd3, 3'd2, 16'h0301, 1'b1, "R7");
    endtask

    // Commit and capture on the same slot in the same cycle: commit wins
    task automatic t_commit_race();
        int st;
        @(negedge clk);
        commit_valid = 1'b1; commit_wave = 2'd1;
        cap_valid = 1'b1; cap_wave = 2'd1; cap_data = 16'hDEAD;
        @(negedge clk);
        commit_valid = 1'b0; cap_valid = 1'b0;
        lg_n = 0;
        abort(2'd3, st);
        check(lg_n == 1, "R7", "replay count after commit+capture race", lg_n, 1);
        chk_entry(0, 2'd3, 3'd3, 16'h0301, 1'b1, "R7");
    endtask

    task automatic t_overflow();
        int st;
        capture(2'd0, 16'h0002);
        capture(2'd0, 16'h0003);
        capture(2'd0, 16'h0004);
        check(ctx_overflow == 1'b0, "R8", "no overflow at capacity", {31'd0, ctx_overflow}, 32'd0);
        capture(2'd0, 16'h0005);
        check(ctx_overflow == 1'b1, "R8", "overflow on extra capture", {31'd0, ctx_overflow}, 32'd1);
        lg_n = 0;
        abort(2'd0, st);
        check(ctx_overflow == 1'b1, "R8", "overflow stays set", {31'd0, ctx_overflow}, 32'd1);
        check(lg_n == 6, "R8", "replay count with full slot", lg_n, 6);
        chk_entry(0, 2'd0, 3'd1, 16'h0001, 1'b1, "R8");
        chk_entry(1, 2'd0, 3'd1, 16'h0002, 1'b1, "R8");
        chk_entry(2, 2'd0, 3'd1, 16'h0003, 1'b1, "R8");
        chk_entry(3, 2'd0, 3'd1, 16'h0004, 1'b1, "R8");
        chk_entry(4, 2'd2, 3'd3, 16'h0201, 1'b1, "R5");
        chk_entry(5, 2'd3, 3'd4, 16'h0301, 1'b1, "R5");
    endtask

    task automatic t_wrap();
        int st;
        // slot 3 is at 4; four more aborts reach 8, which wraps to 0
        commit(2'd3);
        for (int i = 0; i < 4; i++) abort(2'd3, st);
        lg_n = 0;
        send(2'd3, 3'd7, 16'h0B07);
        send(2'd3, 3'd0, 16'hBEEF);
        send(2'd2, 3'd3, 16'h0B23);
        idle(3);
        check(lg_n == 2, "R9", "forwarded count after wrap", lg_n, 2);
        chk_entry(0, 2'd3, 3'd0, 16'hBEEF, 1'b0, "R9");
        chk_entry(1, 2'd2, 3'd3, 16'h0B23, 1'b0, "R4");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_forward();
        t_stale();
        t_abort_replay();
        t_commit();
        t_commit_race();
        t_overflow();
        t_wrap();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule